// File: doc/BRIEF.md
# Single-Cycle 16-bit Accumulator CPU Core

This block is the processing core of a small machine that keeps program and data in separate memories. It has an address register (A), a data register (D) and a 15-bit program counter. Every clock cycle it takes one 16-bit instruction from the instruction memory and, when the instruction needs it, one word from the data memory. It then completes that instruction before the next rising edge.

There are two instruction kinds. An instruction with a clear top bit loads a 15-bit constant into A. An instruction with a set top bit is a compute instruction. It runs a preset-based ALU on D and on either A or the memory word addressed by A. It writes the result to any combination of A, D and memory, and can branch to the address held in A, depending on how the result compares with zero.

Both memories sit outside the block. The memory address always comes from A. The write data and the write strobe come straight from the current instruction's ALU result and destination bits, so a memory write lands on the same rising edge that retires the instruction.

Top module: `cpu16_core`

## Requirements
- R1: While rst is high at a rising edge, the program counter, A and D are all cleared to 0. The first cycle after reset shows pc_o = 0 and mem_addr = 0, and a D read gives 0.
- R2: An instruction with bit 15 = 0 loads bits 14:0 into A at the next edge, with bit 15 of A cleared. It never asserts mem_we and leaves D unchanged.
- R3: A compute instruction has bits 15:13 = 111. Bit 12 picks the second ALU operand: 0 selects A, 1 selects mem_rdata. The first operand is always D.
- R4: Bits 11:6 of a compute instruction control the ALU, in this order from bit 11 down to bit 6. Bit 11 forces x to zero and bit 10 then inverts x. Bit 9 forces y to zero and bit 8 then inverts y. Bit 7 picks x+y (1) or x&y (0), taken modulo 2^16. Bit 6 inverts the result.
- R5: Bits 5:3 of a compute instruction are destination enables. Bit 5 loads A, bit 4 loads D and bit 3 writes memory. Every enabled destination takes the ALU result at the next edge, and a clear bit leaves that destination untouched.
- R6: During a compute instruction with bit 3 set, mem_we is 1 and mem_wdata equals the ALU result in that same cycle. mem_we is 0 whenever bit 3 is clear.
- R7: mem_addr always equals the low 15 bits of A. During an instruction that itself writes A, mem_addr still shows the old A.
- R8: Bits 2:0 of a compute instruction are jump enables. Bit 2 branches on a negative result, bit 1 on a zero result and bit 0 on a positive result. The result's sign is its bit 15. A branch is taken when any enabled condition holds, so 000 never branches and 111 always branches.
- R9: The program counter follows a fixed priority. Reset loads 0. Otherwise a taken branch loads the low 15 bits of A as it was before the edge. Otherwise the counter increments by one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| instr | input | 16 | Instruction word fetched at address pc_o |
| mem_rdata | input | 16 | Data memory word at address mem_addr |
| mem_wdata | output | 16 | ALU result, the value to be written to data memory |
| mem_we | output | 1 | Data memory write enable for the current instruction |
| mem_addr | output | 15 | Data memory address, the low bits of A |
| pc_o | output | 15 | Address of the instruction being executed |

## Verification
The assertions assume that instr and mem_rdata carry known values at every rising edge. They also assume that rst stays high for at least one edge before the first instruction is checked, and that a compute instruction always has bits 14:13 set. The bench meets these conditions by changing inputs only on the falling edge and by holding instr at zero (a harmless constant load) throughout reset. It builds every compute word with a helper that fills in the 111 prefix. Expected ALU and branch results come from a separate model that follows R4 and R8. The bench feeds it register values that it first loaded into A and D through the same instruction stream.

// File: rtl/cpu16_pkg.sv
package cpu16_pkg;
  localparam int INSTR_W = 16;
  localparam int SEL_BIT = 12;

  typedef struct packed {
    logic zero_x;
    logic inv_x;
    logic zero_y;
    logic inv_y;
    logic use_add;
    logic inv_out;
  } alu_ctl_t;

  typedef struct packed {
    logic to_a;
    logic to_d;
    logic to_m;
  } dest_t;

  typedef struct packed {
    logic on_lt;
    logic on_eq;
    logic on_gt;
  } jump_t;
endpackage

// File: rtl/cpu16_alu.sv
module cpu16_alu
  import cpu16_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic [WORD_W-1:0] x_in,
  input  logic [WORD_W-1:0] y_in,
  input  alu_ctl_t          ctl,
  output logic [WORD_W-1:0] result,
  output logic              is_zero,
  output logic              is_neg
);
  logic [WORD_W-1:0] x_pre, y_pre, core;

  always_comb begin
    x_pre = ctl.zero_x ? '0 : x_in;
    if (ctl.inv_x) x_pre = ~x_pre;
    y_pre = ctl.zero_y ? '0 : y_in;
    if (ctl.inv_y) y_pre = ~y_pre;
    core = ctl.use_add ? (x_pre + y_pre) : (x_pre & y_pre);
    result = ctl.inv_out ? ~core : core;
  end

  assign is_zero = (result == '0);
  assign is_neg  = result[WORD_W-1];
endmodule

// File: rtl/cpu16_decode.sv
module cpu16_decode
  import cpu16_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic [WORD_W-1:0] instr,
  output logic              is_compute,
  output logic              y_from_mem,
  output alu_ctl_t          ctl,
  output dest_t             dest,
  output jump_t             jmp
);
  logic unused_prefix;
  assign unused_prefix = ^instr[WORD_W-2:SEL_BIT+1];

  assign is_compute = instr[WORD_W-1];
  assign y_from_mem = instr[SEL_BIT];
  assign ctl        = alu_ctl_t'(instr[11:6]);
  assign dest       = is_compute ? dest_t'(instr[5:3]) : '0;
  assign jmp        = is_compute ? jump_t'(instr[2:0]) : '0;
endmodule

// File: rtl/cpu16_pc.sv
module cpu16_pc #(
  parameter int PC_W = 15
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            load,
  input  logic            inc,
  input  logic [PC_W-1:0] din,
  output logic [PC_W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)       q <= '0;
    else if (load) q <= din;
    else if (inc)  q <= q + 1'b1;
  end

  // R9: reset dominates
  a_r9_pc_reset: assert property (@(posedge clk) rst |=> q == '0);
  // R9: a load takes the target value
  a_r9_pc_load: assert property (@(posedge clk) disable iff (rst)
    load |=> q == $past(din));
  // R9: increment when no load
  a_r9_pc_inc: assert property (@(posedge clk) disable iff (rst)
    (!load && inc) |=> q == $past(q) + 1'b1);
endmodule

// File: rtl/cpu16_core.sv
module cpu16_core
  import cpu16_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [WORD_W-1:0] instr,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic [WORD_W-1:0] mem_wdata,
  output logic              mem_we,
  output logic [WORD_W-2:0] mem_addr,
  output logic [WORD_W-2:0] pc_o
);
  localparam int ADDR_W = WORD_W - 1;

  logic [WORD_W-1:0] a_reg, d_reg, y_op, alu_out;
  logic              is_compute, y_from_mem, res_zero, res_neg, take;
  alu_ctl_t          ctl;
  dest_t             dest;
  jump_t             jmp;

  cpu16_decode #(.WORD_W(WORD_W)) u_dec (
    .instr(instr), .is_compute(is_compute), .y_from_mem(y_from_mem),
    .ctl(ctl), .dest(dest), .jmp(jmp)
  );

  assign y_op = y_from_mem ? mem_rdata : a_reg;

  cpu16_alu #(.WORD_W(WORD_W)) u_alu (
    .x_in(d_reg), .y_in(y_op), .ctl(ctl),
    .result(alu_out), .is_zero(res_zero), .is_neg(res_neg)
  );

  assign take = (jmp.on_lt & res_neg) | (jmp.on_eq & res_zero) |
                (jmp.on_gt & ~res_neg & ~res_zero);

  always_ff @(posedge clk) begin
    if (rst)              a_reg <= '0;
    else if (!is_compute) a_reg <= {1'b0, instr[ADDR_W-1:0]};
    else if (dest.to_a)   a_reg <= alu_out;
  end

  always_ff @(posedge clk) begin
    if (rst)            d_reg <= '0;
    else if (dest.to_d) d_reg <= alu_out;
  end

  cpu16_pc #(.PC_W(ADDR_W)) u_pc (
    .clk(clk), .rst(rst), .load(take), .inc(1'b1),
    .din(a_reg[ADDR_W-1:0]), .q(pc_o)
  );

  assign mem_addr  = a_reg[ADDR_W-1:0];
  assign mem_wdata = alu_out;
  assign mem_we    = dest.to_m;

  // R2: constant load reaches A
  a_r2_const_to_a: assert property (@(posedge clk) disable iff (rst)
    !instr[WORD_W-1] |=> mem_addr == $past(instr[ADDR_W-1:0]));
  // R2: constant load never writes memory
  a_r2_no_write: assert property (@(posedge clk) disable iff (rst)
    !instr[WORD_W-1] |-> !mem_we);
  // R2: constant load leaves D alone
  a_r2_d_hold: assert property (@(posedge clk) disable iff (rst)
    !instr[WORD_W-1] |=> d_reg == $past(d_reg));
  // R8: jump field 111 always branches to old A
  a_r8_always_jump: assert property (@(posedge clk) disable iff (rst)
    (instr[WORD_W-1] && instr[2:0] == 3'b111) |=> pc_o == $past(mem_addr));
  // R8: jump field 000 never branches
  a_r8_never_jump: assert property (@(posedge clk) disable iff (rst)
    (instr[WORD_W-1] && instr[2:0] == 3'b000) |=> pc_o == $past(pc_o) + 1'b1);
endmodule

// File: tb/cpu16_core_test.sv
module cpu16_core_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] instr = '0;
  logic [15:0] mem_rdata = '0;
  logic [15:0] mem_wdata;
  logic        mem_we;
  logic [14:0] mem_addr;
  logic [14:0] pc_o;
  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cpu16_core uut (
    .clk(clk), .rst(rst), .instr(instr), .mem_rdata(mem_rdata),
    .mem_wdata(mem_wdata), .mem_we(mem_we), .mem_addr(mem_addr), .pc_o(pc_o)
  );

  function automatic logic [15:0] ref_alu(input logic [15:0] x, input logic [15:0] y,
                                          input logic [5:0] c);
    logic [15:0] xx, yy, r;
    xx = c[5] ? 16'h0 : x;
    if (c[4]) xx = ~xx;
    yy = c[3] ? 16'h0 : y;
    if (c[2]) yy = ~yy;
    r = c[1] ? xx + yy : xx & yy;
    if (c[0]) r = ~r;
    return r;
  endfunction

  function automatic logic [15:0] cins(input logic a, input logic [5:0] c,
                                       input logic [2:0] d, input logic [2:0] j);
    return {3'b111, a, c, d, j};
  endfunction

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step(input logic [15:0] ins, input logic [15:0] rd);
    @(negedge clk);
    instr = ins;
    mem_rdata = rd;
    #1;
  endtask

  task automatic set_d(input logic [15:0] v);
    if (v[15]) begin
      step({1'b0, ~v[14:0]}, 16'h0);
      step(cins(1'b0, 6'b110001, 3'b010, 3'b000), 16'h0);
    end else begin
      step({1'b0, v[14:0]}, 16'h0);
      step(cins(1'b0, 6'b110000, 3'b010, 3'b000), 16'h0);
    end
  endtask

  task automatic t_reset;
    rst = 1'b1;
    instr = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    chk("R1 pc after reset", {1'b0, pc_o}, 16'h0);
    chk("R1 A after reset", {1'b0, mem_addr}, 16'h0);
    step(cins(1'b0, 6'b001100, 3'b001, 3'b000), 16'h0);
    chk("R1 D after reset", mem_wdata, 16'h0);
  endtask

  task automatic t_const_load;
    logic [14:0] p;
    set_d(16'h0055);
    step(16'h1234, 16'h0);
    chk("R2 no write on const load", {15'h0, mem_we}, 16'h0);
    p = pc_o;
    step(16'h7FFF, 16'h0);
    chk("R2 A loaded", {1'b0, mem_addr}, 16'h1234);
    chk("R9 pc increments", {1'b0, pc_o}, {1'b0, p + 15'd1});
    step(cins(1'b0, 6'b001100, 3'b001, 3'b000), 16'h0);
    chk("R2 A upper bit clear, all ones low", {1'b0, mem_addr}, 16'h7FFF);
    chk("R2 D unchanged", mem_wdata, 16'h0055);
  endtask

  task automatic t_alu(input logic [15:0] dv, input logic [15:0] av, input logic [15:0] mv);
    logic [5:0] codes [18];
    codes = '{6'b101010, 6'b111111, 6'b111010, 6'b001100, 6'b110000, 6'b001101,
              6'b110001, 6'b001111, 6'b110011, 6'b011111, 6'b110111, 6'b001110,
              6'b110010, 6'b000010, 6'b010011, 6'b000111, 6'b000000, 6'b010101};
    set_d(dv);
    step({1'b0, av[14:0]}, 16'h0);
    for (int i = 0; i < 18; i++) begin
      step(cins(1'b0, codes[i], 3'b001, 3'b000), mv);
      chk("R4 ALU with A operand", mem_wdata, ref_alu(dv, {1'b0, av[14:0]}, codes[i]));
      chk("R6 write strobe", {15'h0, mem_we}, 16'h1);
      step(cins(1'b1, codes[i], 3'b001, 3'b000), mv);
      chk("R3 ALU with memory operand", mem_wdata, ref_alu(dv, mv, codes[i]));
    end
  endtask

  task automatic t_dest;
    set_d(16'd5);
    step(16'd9, 16'h0);
    step(cins(1'b0, 6'b000010, 3'b110, 3'b000), 16'h0);
    chk("R6 no write when bit 3 clear", {15'h0, mem_we}, 16'h0);
    step(cins(1'b0, 6'b001100, 3'b001, 3'b000), 16'h0);
    chk("R5 AD loads D", mem_wdata, 16'd14);
    chk("R5 AD loads A", {1'b0, mem_addr}, 16'd14);
    step(cins(1'b0, 6'b011111, 3'b000, 3'b000), 16'h0);
    chk("R5 null dest no write", {15'h0, mem_we}, 16'h0);
    step(cins(1'b0, 6'b001110, 3'b111, 3'b000), 16'h0);
    chk("R6 AMD write data", mem_wdata, 16'd13);
    chk("R7 address is old A", {1'b0, mem_addr}, 16'd14);
    step(cins(1'b0, 6'b001100, 3'b001, 3'b000), 16'h0);
    chk("R5 AMD loads D", mem_wdata, 16'd13);
    chk("R5 AMD loads A", {1'b0, mem_addr}, 16'd13);
  endtask

  task automatic t_jump;
    logic [15:0] dvals [3];
    logic [14:0] p, tgt;
    logic neg, zer, pos, tk;
    dvals = '{16'hFFFD, 16'h0000, 16'h0007};
    for (int j = 0; j < 8; j++) begin
      for (int k = 0; k < 3; k++) begin
        set_d(dvals[k]);
        tgt = 15'h0100 + 15'(j * 4 + k);
        step({1'b0, tgt}, 16'h0);
        step(cins(1'b0, 6'b001100, 3'b000, 3'(j)), 16'h0);
        p = pc_o;
        neg = dvals[k][15];
        zer = (dvals[k] == 16'h0);
        pos = !neg && !zer;
        tk = (j[2] && neg) || (j[1] && zer) || (j[0] && pos);
        step(16'h0, 16'h0);
        chk("R8 branch decision", {1'b0, pc_o}, {1'b0, tk ? tgt : p + 15'd1});
      end
    end
  endtask

  task automatic t_reset_priority;
    step(16'h0200, 16'h0);
    @(negedge clk);
    instr = cins(1'b0, 6'b101010, 3'b000, 3'b111);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    instr = 16'h0;
    #1;
    chk("R9 reset beats jump", {1'b0, pc_o}, 16'h0);
    chk("R1 reset clears A", {1'b0, mem_addr}, 16'h0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks + 1);
    $finish;
  end

  initial begin
    t_reset();
    t_const_load();
    t_alu(16'h00F3, 16'h0A5C, 16'hBEEF);
    t_alu(16'hFF21, 16'h7001, 16'h8000);
    t_dest();
    t_jump();
    t_reset_priority();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule